// File: doc/BRIEF.md
# Multi-Lane DDR Sample Serializer

This block turns parallel converter samples into narrow serial streams for a source-synchronous link. At the start of each sample period it captures one word per channel. It can recode the word from offset binary to two's complement. It then shifts the word out over one, two or four lanes per channel.

A forwarded data clock runs beside the lanes. A receiver latches the lanes on both edges of that clock. A frame marker is high for the first half of every sample period, and its rising edge marks the first bits of a new word.

Everything runs from one internal clock `clk`. `clk` runs at twice the per-lane bit rate, so every bit is held for two `clk` cycles. The forwarded clock changes midway through each bit, between two data changes.

Lane count and coding are sampled only at sample boundaries. A change on those inputs in the middle of a word therefore never disturbs the word in flight. The next period then starts from a clean counter.

Top module: `ddr_sample_serializer`

## Requirements
- R1: While `rst_n` is low, all lanes, `dco_o` and `frame_o` are low.
- R2: `lane_mode_i` selects the active lanes per channel: 0 gives one lane, 1 gives two lanes, 2 gives four lanes, and 3 behaves as one lane. Lanes at or above the active count are held at 0.
- R3: Bits leave MSB first and interleaved across lanes. With L active lanes, lane k carries bit W-1-k-j·L in bit slot j. Lane k of channel c is `lanes_o[c*4+k]`.
- R4: Each bit slot lasts two `clk` cycles. A sample period lasts 2·W/L cycles, and periods follow each other with no gap.
- R5: `dco_o` is low in the first cycle of a period. In cycle t of the period it equals ((t+1)/2) mod 2, so it toggles midway between lane changes.
- R6: `frame_o` is high for cycles 0 to W/L−1 of each period and low for the rest.
- R7: With `twos_i`=0 the word goes out unchanged (offset binary). With `twos_i`=1 its MSB is inverted: 0x8000 becomes 0x0000, 0xFFFF becomes 0x7FFF, and 0x0000 becomes 0x8000.
- R8: `load_o` is high in the last cycle of each period, and also while the block waits for the first period after reset. `sample_i`, `lane_mode_i` and `twos_i` are captured at the clock edge that ends that cycle.
- R9: Changes on `sample_i`, `lane_mode_i` or `twos_i` while `load_o` is low have no effect on the current period.
- R10: Each channel serializes its own word. All channels share the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the per-lane bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode_i | input | 2 | Lane count select, taken at sample boundaries |
| twos_i | input | 1 | 1 selects two's complement output coding |
| sample_i | input | NUM_CH*SAMPLE_W | One word per channel, channel 0 in the low bits |
| load_o | output | 1 | High in the cycle whose closing edge captures the inputs |
| dco_o | output | 1 | Forwarded data clock, for latching on both edges |
| frame_o | output | 1 | High for the first half of each sample period |
| lanes_o | output | NUM_CH*4 | Serial lanes, four per channel |

## Verification
The hardest situation to reach is a mode, coding and sample change that lands in the middle of a period, followed directly by a period of a different length. The bench holds its stimulus aligned to `load_o` and changes all three inputs a few cycles into a one-lane period. It checks that the old word finishes intact. It then checks that the next period comes back-to-back, at the new four-lane length, with the new coding and with the forwarded clock restarted low.

// File: rtl/dss_pkg.sv
`timescale 1ns/1ps
package dss_pkg;
   localparam int MAX_LANES = 4;

   typedef enum logic [1:0] {
      LM_ONE  = 2'd0,
      LM_TWO  = 2'd1,
      LM_FOUR = 2'd2,
      LM_ALT  = 2'd3
   } lane_mode_e;

   // log2 of the active lane count for a mode code
   function automatic logic [1:0] lane_lg(input logic [1:0] code);
      case (lane_mode_e'(code))
         LM_TWO:  return 2'd1;
         LM_FOUR: return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

   function automatic int lane_count(input logic [1:0] lg);
      return 1 << lg;
   endfunction
endpackage

// File: rtl/dss_coder.sv
`timescale 1ns/1ps
module dss_coder #(
   parameter int W = 16
) (
   input  logic         twos_i,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] word_o
);
   generate
      if (W > 1) begin : g_wide
         assign word_o = {raw_i[W-1] ^ twos_i, raw_i[W-2:0]};
      end else begin : g_narrow
         assign word_o = raw_i ^ twos_i;
      end
   endgenerate
endmodule

// File: rtl/dss_timing.sv
`timescale 1ns/1ps
module dss_timing #(
   parameter int W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] lane_mode_i,
   output logic [1:0] lg_o,
   output logic       load_o,
   output logic       shift_o,
   output logic       dco_o,
   output logic       frame_o
);
   import dss_pkg::*;

   localparam int CW = $clog2(2 * W);

   logic          started;
   logic [CW-1:0] cnt;
   logic [1:0]    lg_q;
   logic [CW:0]   span;
   logic [CW-1:0] last_cnt;

   assign span     = (CW+1)'(2 * W) >> lg_q;
   assign last_cnt = CW'(span - 1'b1);
   assign load_o   = !started || (cnt == last_cnt);
   assign shift_o  = started && cnt[0] && !load_o;
   assign dco_o    = started && (cnt[1] ^ cnt[0]);
   assign frame_o  = started && ({1'b0, cnt} < (span >> 1));
   assign lg_o     = lg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         cnt     <= '0;
         lg_q    <= 2'd0;
      end else if (load_o) begin
         started <= 1'b1;
         cnt     <= '0;
         lg_q    <= lane_lg(lane_mode_i);
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_o) |-> $stable(lg_o));
   // R5
   dco_quiet_on_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_o |=> $stable(dco_o));
   // R6
   load_then_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> (frame_o && !dco_o));
endmodule

// File: rtl/dss_shifter.sv
`timescale 1ns/1ps
module dss_shifter #(
   parameter int W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_i,
   input  logic                          shift_i,
   input  logic [1:0]                    lg_i,
   input  logic [W-1:0]                  word_i,
   output logic [dss_pkg::MAX_LANES-1:0] lanes_o
);
   import dss_pkg::*;

   logic [W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
      end else if (load_i) begin
         sreg <= word_i;
      end else if (shift_i) begin
         sreg <= sreg << lane_count(lg_i);
      end
   end

   generate
      for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
         assign lanes_o[k] = (k < lane_count(lg_i)) ? sreg[W-1-k] : 1'b0;
      end
   endgenerate

   // R4
   lanes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load_i) && !$past(shift_i)) |-> $stable(lanes_o));
   // R2
   idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lg_i == 2'd0) |-> (lanes_o[MAX_LANES-1:1] == '0));
endmodule

// File: rtl/ddr_sample_serializer.sv
`timescale 1ns/1ps
module ddr_sample_serializer #(
   parameter int SAMPLE_W = 16,
   parameter int NUM_CH   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 lane_mode_i,
   input  logic                       twos_i,
   input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
   output logic                       load_o,
   output logic                       dco_o,
   output logic                       frame_o,
   output logic [NUM_CH*4-1:0]        lanes_o
);
   import dss_pkg::*;

   generate
      if (SAMPLE_W < 8 || (SAMPLE_W % (2 * MAX_LANES)) != 0) begin : g_bad_width
         $error("SAMPLE_W must be a multiple of twice the lane maximum");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least one");
      end
   endgenerate

   logic [1:0] lg;
   logic       shift;

   dss_timing #(.W(SAMPLE_W)) u_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_mode_i (lane_mode_i),
      .lg_o        (lg),
      .load_o      (load_o),
      .shift_o     (shift),
      .dco_o       (dco_o),
      .frame_o     (frame_o)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [SAMPLE_W-1:0] coded;

         dss_coder #(.W(SAMPLE_W)) u_coder (
            .twos_i (twos_i),
            .raw_i  (sample_i[c*SAMPLE_W +: SAMPLE_W]),
            .word_o (coded)
         );

         dss_shifter #(.W(SAMPLE_W)) u_shift (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_o),
            .shift_i (shift),
            .lg_i    (lg),
            .word_i  (coded),
            .lanes_o (lanes_o[c*MAX_LANES +: MAX_LANES])
         );
      end
   endgenerate
endmodule

// File: tb/ddr_sample_serializer_bench.sv
`timescale 1ns/1ps
module ddr_sample_serializer_bench;
   localparam int W  = 16;
   localparam int NC = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      lane_mode_i = 2'd0;
   logic            twos_i = 1'b0;
   logic [NC*W-1:0] sample_i = '0;
   logic            load_o, dco_o, frame_o;
   logic [NC*4-1:0] lanes_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ddr_sample_serializer #(.SAMPLE_W(W), .NUM_CH(NC)) u_ddr_sample_serializer (
      .clk(clk), .rst_n(rst_n), .lane_mode_i(lane_mode_i), .twos_i(twos_i),
      .sample_i(sample_i), .load_o(load_o), .dco_o(dco_o), .frame_o(frame_o),
      .lanes_o(lanes_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One whole sample period, aligned to load_o. Optional mid-period disturbance.
   task automatic run_sample(input logic [NC*W-1:0] smp, input logic [1:0] mode,
                             input bit twos, input string req,
                             input bit mid_en, input logic [1:0] mid_mode);
      int nl, per, guard;
      bit ok_l[NC];
      bit ok_d, ok_f, ok_ld;
      int al[NC], el[NC];
      int ad, ed, af, ef, ald, eld;
      logic [W-1:0] cw[NC];
      nl = (mode == 2'd1) ? 2 : (mode == 2'd2) ? 4 : 1;
      per = 2 * W / nl;
      for (int c = 0; c < NC; c++) begin
         cw[c] = smp[c*W +: W] ^ (twos ? 16'h8000 : 16'h0000);
         ok_l[c] = 1'b1; al[c] = 0; el[c] = 0;
      end
      ok_d = 1'b1; ok_f = 1'b1; ok_ld = 1'b1;
      ad = 0; ed = 0; af = 0; ef = 0; ald = 0; eld = 0;
      lane_mode_i = mode;
      twos_i = twos;
      sample_i = smp;
      guard = 0;
      while (!load_o && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      @(posedge clk);
      @(negedge clk);
      for (int t = 0; t < per; t++) begin
         int j;
         int expd, expf, expld;
         j = t / 2;
         for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 4; k++) begin
               int e;
               e = (k < nl) ? int'(cw[c][W-1-k-j*nl]) : 0;
               if (int'(lanes_o[c*4+k]) != e && ok_l[c]) begin
                  ok_l[c] = 1'b0; al[c] = int'(lanes_o[c*4 +: 4]); el[c] = t*16 + k;
               end
            end
         end
         expd = ((t + 1) / 2) % 2;
         expf = (t < per / 2) ? 1 : 0;
         expld = (t == per - 1) ? 1 : 0;
         if (int'(dco_o) != expd && ok_d) begin ok_d = 1'b0; ad = int'(dco_o); ed = expd; end
         if (int'(frame_o) != expf && ok_f) begin ok_f = 1'b0; af = int'(frame_o); ef = expf; end
         if (int'(load_o) != expld && ok_ld) begin ok_ld = 1'b0; ald = int'(load_o); eld = expld; end
         if (mid_en && t == 3) begin
            // R9: disturb every input in mid-period
            lane_mode_i = mid_mode;
            twos_i = ~twos;
            sample_i = ~smp;
         end
         if (t < per - 1) @(negedge clk);
      end
      for (int c = 0; c < NC; c++)
         check(ok_l[c], req, $sformatf("lanes ch%0d (R3 R10, exp=cycle*16+lane)", c), al[c], el[c]);
      check(ok_d, req, "dco (R5)", ad, ed);
      check(ok_f, req, "frame (R6)", af, ef);
      check(ok_ld, req, "load and period length (R4 R8)", ald, eld);
   endtask

   task automatic test_reset();
      // R1
      repeat (3) @(negedge clk);
      check(lanes_o == '0, "R1", "lanes in reset", int'(lanes_o), 0);
      check(dco_o == 1'b0, "R1", "dco in reset", int'(dco_o), 0);
      check(frame_o == 1'b0, "R1", "frame in reset", int'(frame_o), 0);
      rst_n = 1'b1;
   endtask

   task automatic test_one_lane();
      run_sample({16'h1234, 16'hA5C3}, 2'd0, 1'b0, "R3", 1'b0, 2'd0);
      run_sample({16'h0F0F, 16'hFFFF}, 2'd0, 1'b0, "R4", 1'b0, 2'd0);
   endtask

   task automatic test_twos();
      // R7: mid-scale, positive full scale, negative full scale
      run_sample({16'hFFFF, 16'h8000}, 2'd0, 1'b1, "R7", 1'b0, 2'd0);
      run_sample({16'h0000, 16'h7FFF}, 2'd1, 1'b1, "R7", 1'b0, 2'd0);
   endtask

   task automatic test_two_lane();
      run_sample({16'hC0DE, 16'h5A96}, 2'd1, 1'b0, "R2", 1'b0, 2'd0);
   endtask

   task automatic test_four_lane();
      run_sample({16'h9E37, 16'h0001}, 2'd2, 1'b0, "R2", 1'b0, 2'd0);
      run_sample({16'h8421, 16'hBEEF}, 2'd2, 1'b1, "R2", 1'b0, 2'd0);
   endtask

   task automatic test_alt_mode();
      run_sample({16'h3C69, 16'hE00E}, 2'd3, 1'b0, "R2", 1'b0, 2'd0);
   endtask

   task automatic test_mid_change();
      // R9: one-lane period disturbed, then the four-lane period that follows
      run_sample({16'h6B1D, 16'h2F80}, 2'd0, 1'b0, "R9", 1'b1, 2'd2);
      run_sample({16'h6B1D, 16'h2F80} ^ 32'hFFFF_FFFF, 2'd2, 1'b1, "R9", 1'b0, 2'd0);
      run_sample({16'h1357, 16'h2468}, 2'd1, 1'b0, "R9", 1'b1, 2'd0);
      run_sample({16'h1357, 16'h2468} ^ 32'hFFFF_FFFF, 2'd0, 1'b1, "R9", 1'b0, 2'd0);
   endtask

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL R8 watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      test_reset();
      test_one_lane();
      test_twos();
      test_two_lane();
      test_four_lane();
      test_alt_mode();
      test_mid_change();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule